// File: doc/BRIEF.md
# Frame-Sync Supervisor Timer

This block gives a host processor two supervision lines derived from the 8 kHz frame-sync rate. The first is an active-low interrupt request on a fixed 8 ms grid. It latches low at each grid point and stays low until the processor writes a release strobe. The second is a watchdog line. It sits high and, unless the processor restarts it, drops low for the final 4 ms of every 500 ms period.

Both timers run on a single-cycle enable, `sync_tick`, that marks each frame. When frames stop arriving, both timers freeze and neither line changes. The interrupt grid runs freely from reset release, so a release never shifts it. The watchdog counter starts again from zero on every restart strobe.

Top module: `supervisor_timer`

## Requirements
- R1: While `rst_n` is sampled low, `irq_n` and `wdt_n` are both high in the following cycle, and both timers restart from zero.
- R2: `irq_n` first goes low in the cycle after the 64th `sync_tick` following reset release, and not earlier.
- R3: Once low, `irq_n` stays low until a cycle with `irq_release` high. The cycle after the release, it is high.
- R4: The 64-tick interrupt grid is not restarted by a release. After a release, `irq_n` goes low again at the next grid point, which can be fewer than 64 ticks later.
- R5: A release while `irq_n` is already high has no effect. A release in the same cycle as a grid point leaves `irq_n` low, because assertion wins.
- R6: With no restart, `wdt_n` is low while the watchdog count is in 3968..3999 of a 4000-tick period. That gives exactly 32 ticks low at the end of every period, repeating.
- R7: A `wdt_restart` strobe clears the watchdog count. `wdt_n` is high the cycle after the strobe, even in the middle of a pulse, and the next low begins 3968 ticks later.
- R8: In cycles without `sync_tick`, `irq_release` or `wdt_restart`, neither output changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_tick | input | 1 | One-cycle pulse per 125 us frame |
| irq_release | input | 1 | One-cycle interrupt release strobe from the processor |
| wdt_restart | input | 1 | One-cycle watchdog restart strobe from the processor |
| irq_n | output | 1 | Active-low latched interrupt request |
| wdt_n | output | 1 | Active-low watchdog pulse output |

## Verification
Some properties can be checked on every cycle, and the assertions cover those:
- both outputs go high after reset;
- the outputs only fall on a tick;
- the interrupt holds low until released, and a release clears it;
- a restart ends a watchdog pulse;
- no watchdog pulse lasts more than 32 ticks;
- outputs are frozen when the inputs are idle.

Exact distances need the bench scenarios, which track a tick count independent of the design. These include the 64-tick first assertion, the short gap after a late release, the 3968/4000-tick watchdog edges across two periods, and the restart phase. The same applies to the collision between a release and a grid point, to reset in mid-pulse, and to a long stretch with no frame sync.

// File: rtl/sup_timer_pkg.sv
// Package: shared defaults for the frame-sync supervisor timer.
// Assumes an 8 kHz frame enable, so one tick is 125 us.
package sup_timer_pkg;
    localparam int unsigned DEF_IRQ_TICKS = 64;    // 8 ms
    localparam int unsigned DEF_WDT_TICKS = 4000;  // 500 ms
    localparam int unsigned DEF_WDT_LOW   = 32;    // 4 ms

    // Counter width needed to hold values 0..modulus-1.
    function automatic int unsigned mod_width(input int unsigned modulus);
        return (modulus < 2) ? 1 : $clog2(modulus);
    endfunction
endpackage

// File: rtl/frame_counter.sv
// Module: frame_counter
// Modulo-MODULUS counter that advances on an enable and clears synchronously.
// Flags the tick on which it wraps. Assumes MODULUS >= 2. A clear has
// priority over an advance in the same cycle.
module frame_counter #(
    parameter int unsigned MODULUS = 64,
    localparam int unsigned W = sup_timer_pkg::mod_width(MODULUS)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] LAST = W'(MODULUS - 1);

    // Wrap strobe: advancing from the final count.
    always_comb wrap = adv && (count == LAST);

    // Count register: reset or clear to zero, otherwise step modulo MODULUS.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (adv) begin
            count <= wrap ? '0 : count + 1'b1;
        end
    end
endmodule

// File: rtl/irq_flag.sv
// Module: irq_flag
// Active-low interrupt latch. It is set (driven low) by a grid strobe and
// released (driven high) by a processor strobe. Set wins when both arrive
// in the same cycle, so a grid point is never lost.
module irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic release_evt,
    output logic irq_n
);
    // Latch state: high after reset, low on a grid point, high on release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_n <= 1'b1;
        end else if (set_evt) begin
            irq_n <= 1'b0;
        end else if (release_evt) begin
            irq_n <= 1'b1;
        end
    end
endmodule

// File: rtl/wdt_window.sv
// Module: wdt_window
// Decodes the watchdog period count into the active-low pulse that covers
// the last LOW_LEN counts of the period. Assumes LOW_LEN < PERIOD and that
// count never exceeds PERIOD-1.
module wdt_window #(
    parameter int unsigned PERIOD  = 4000,
    parameter int unsigned LOW_LEN = 32,
    localparam int unsigned W = sup_timer_pkg::mod_width(PERIOD)
) (
    input  logic [W-1:0] count,
    output logic         wdt_n
);
    localparam logic [W-1:0] START = W'(PERIOD - LOW_LEN);

    // Pulse window: low from START up to the end of the period.
    always_comb wdt_n = (count < START);
endmodule

// File: rtl/supervisor_timer.sv
// Module: supervisor_timer
// Frame-sync supervisor. A free-running interrupt grid latches irq_n low
// every IRQ_TICKS ticks until it is released. A restartable watchdog period
// drives wdt_n low for the last WDT_LOW ticks of every WDT_TICKS ticks.
// Assumes sync_tick is a single-cycle pulse that is synchronous to clk.
module supervisor_timer #(
    parameter int unsigned IRQ_TICKS = sup_timer_pkg::DEF_IRQ_TICKS,
    parameter int unsigned WDT_TICKS = sup_timer_pkg::DEF_WDT_TICKS,
    parameter int unsigned WDT_LOW   = sup_timer_pkg::DEF_WDT_LOW
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_tick,
    input  logic irq_release,
    input  logic wdt_restart,
    output logic irq_n,
    output logic wdt_n
);
    localparam int unsigned IW = sup_timer_pkg::mod_width(IRQ_TICKS);
    localparam int unsigned WW = sup_timer_pkg::mod_width(WDT_TICKS);

    logic [IW-1:0] irq_cnt;
    logic          irq_grid;
    logic [WW-1:0] wdt_cnt;
    logic          wdt_wrap_unused;

    // Interrupt grid: free-running, never cleared by a release.
    frame_counter #(.MODULUS(IRQ_TICKS)) u_irq_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (1'b0),
        .adv   (sync_tick),
        .count (irq_cnt),
        .wrap  (irq_grid)
    );

    irq_flag u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_evt     (irq_grid),
        .release_evt (irq_release),
        .irq_n       (irq_n)
    );

    // Watchdog period: cleared by a restart, otherwise wraps on its own.
    frame_counter #(.MODULUS(WDT_TICKS)) u_wdt_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (wdt_restart),
        .adv   (sync_tick),
        .count (wdt_cnt),
        .wrap  (wdt_wrap_unused)
    );

    wdt_window #(.PERIOD(WDT_TICKS), .LOW_LEN(WDT_LOW)) u_wdt_win (
        .count (wdt_cnt),
        .wdt_n (wdt_n)
    );

    // Unused terminal-count flag of the watchdog counter.
    logic unused_ok;
    always_comb unused_ok = ^{wdt_wrap_unused, irq_cnt};
endmodule

// File: rtl/sup_timer_checker.sv
// Module: sup_timer_checker
// Port-level properties of supervisor_timer. It is bound to the top module.
// A tick counter bounds the watchdog pulse length without deep $past.
module sup_timer_checker #(
    parameter int unsigned WDT_LOW = 32
) (
    input logic clk,
    input logic rst_n,
    input logic sync_tick,
    input logic irq_release,
    input logic wdt_restart,
    input logic irq_n,
    input logic wdt_n
);
    localparam int unsigned LW = $clog2(WDT_LOW + 1) + 1;
    logic [LW-1:0] low_ticks;

    // Ticks seen while wdt_n is low; cleared whenever it is high.
    always_ff @(posedge clk) begin
        if (!rst_n || wdt_n) begin
            low_ticks <= '0;
        end else if (sync_tick) begin
            low_ticks <= low_ticks + 1'b1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_n && wdt_n));

    assert_irq_falls_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && !sync_tick) |=> irq_n);

    assert_irq_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_n && !irq_release) |=> !irq_n);

    assert_irq_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_release && !sync_tick) |=> irq_n);

    assert_wdt_falls_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_n && !sync_tick) |=> wdt_n);

    assert_wdt_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        low_ticks <= LW'(WDT_LOW));

    assert_restart_ends_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_restart |=> wdt_n);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_tick && !irq_release && !wdt_restart) |=> ($stable(irq_n) && $stable(wdt_n)));
endmodule

bind supervisor_timer sup_timer_checker #(.WDT_LOW(WDT_LOW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_tick   (sync_tick),
    .irq_release (irq_release),
    .wdt_restart (wdt_restart),
    .irq_n       (irq_n),
    .wdt_n       (wdt_n)
);

// File: tb/sim_supervisor_timer.sv
// Bench for supervisor_timer. A vector table of {ticks, action, irq, wdt}
// runs first, then directed tests of reset, collision and missing sync.
module sim_supervisor_timer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_tick = 1'b0;
    logic irq_release = 1'b0;
    logic wdt_restart = 1'b0;
    logic irq_n;
    logic wdt_n;

    int checks = 0;
    int failures = 0;
    int total_ticks = 0;

    always #10 clk = ~clk;  // 50 MHz

    supervisor_timer u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_tick   (sync_tick),
        .irq_release (irq_release),
        .wdt_restart (wdt_restart),
        .irq_n       (irq_n),
        .wdt_n       (wdt_n)
    );

    // Vector: [15:4] ticks, [3:2] action (0 none, 1 release, 2 restart),
    // [1] expected irq_n, [0] expected wdt_n. Action comes before the ticks.
    localparam int NV = 20;
    localparam logic [15:0] VEC [0:NV-1] = '{
        {12'd0,    2'd0, 1'b1, 1'b1},  // R1 idle after reset
        {12'd63,   2'd0, 1'b1, 1'b1},  // R2 one tick short
        {12'd1,    2'd0, 1'b0, 1'b1},  // R2 at 64
        {12'd10,   2'd0, 1'b0, 1'b1},  // R3 holds
        {12'd0,    2'd1, 1'b1, 1'b1},  // R3 release
        {12'd53,   2'd0, 1'b1, 1'b1},  // R4 total 127
        {12'd1,    2'd0, 1'b0, 1'b1},  // R4 grid at 128
        {12'd0,    2'd1, 1'b1, 1'b1},  // R3 release
        {12'd0,    2'd1, 1'b1, 1'b1},  // R5 release while high
        {12'd64,   2'd0, 1'b0, 1'b1},  // R4 total 192
        {12'd3775, 2'd0, 1'b0, 1'b1},  // R6 total 3967
        {12'd1,    2'd0, 1'b0, 1'b0},  // R6 pulse at 3968
        {12'd31,   2'd0, 1'b0, 1'b0},  // R6 3999
        {12'd1,    2'd0, 1'b0, 1'b1},  // R6 period end 4000
        {12'd3967, 2'd1, 1'b0, 1'b1},  // R6 total 7967
        {12'd1,    2'd0, 1'b0, 1'b0},  // R6 second pulse 7968
        {12'd0,    2'd2, 1'b0, 1'b1},  // R7 restart mid-pulse
        {12'd3967, 2'd0, 1'b0, 1'b1},  // R7 one short
        {12'd1,    2'd0, 1'b0, 1'b0},  // R7 3968 after restart
        {12'd16,   2'd0, 1'b0, 1'b0}   // R6 still inside pulse
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at ticks=%0d", req, act, exp, total_ticks);
        end
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sync_tick = 1'b1;
            @(negedge clk) sync_tick = 1'b0;
            total_ticks++;
        end
    endtask

    task automatic do_action(input logic [1:0] a);
        if (a == 2'd1) begin
            @(negedge clk) irq_release = 1'b1;
            @(negedge clk) irq_release = 1'b0;
        end else if (a == 2'd2) begin
            @(negedge clk) wdt_restart = 1'b1;
            @(negedge clk) wdt_restart = 1'b0;
        end
    endtask

    initial begin
        logic hold_irq;
        logic hold_wdt;
        repeat (4) @(negedge clk);
        check("R1 irq in reset", irq_n, 1'b1);
        check("R1 wdt in reset", wdt_n, 1'b1);
        rst_n = 1'b1;
        total_ticks = 0;

        for (int v = 0; v < NV; v++) begin
            do_action(VEC[v][3:2]);
            do_ticks(int'(VEC[v][15:4]));
            check($sformatf("R2-table irq vec%0d", v), irq_n, VEC[v][1]);
            check($sformatf("R6-table wdt vec%0d", v), wdt_n, VEC[v][0]);
        end

        // R8: no frame sync for a long stretch, nothing moves.
        hold_irq = irq_n;
        hold_wdt = wdt_n;
        repeat (600) @(negedge clk);
        check("R8 irq frozen", irq_n, hold_irq);
        check("R8 wdt frozen", wdt_n, hold_wdt);

        // R5: release arrives in the same cycle as a grid point.
        do_action(2'd1);
        check("R5 released first", irq_n, 1'b1);
        do_ticks((63 - (total_ticks % 64) + 64) % 64);
        check("R4 before grid", irq_n, 1'b1);
        @(negedge clk) begin sync_tick = 1'b1; irq_release = 1'b1; end
        @(negedge clk) begin sync_tick = 1'b0; irq_release = 1'b0; end
        total_ticks++;
        check("R5 collision keeps low", irq_n, 1'b0);

        // R1: reset in the middle of operation.
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R1 irq after mid reset", irq_n, 1'b1);
        check("R1 wdt after mid reset", wdt_n, 1'b1);
        rst_n = 1'b1;
        total_ticks = 0;
        do_ticks(63);
        check("R2 restart 63", irq_n, 1'b1);
        do_ticks(1);
        check("R2 restart 64", irq_n, 1'b0);
        check("R1 wdt restarted", wdt_n, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule